// File: doc/BRIEF.md
# Eight-bit Timer with Compare Match and Edge Capture

This block is an 8-bit up-counter driven by a tick. The tick comes either from an internal divider of the system clock or from the synchronised rising edges of an external clock pin. The count is compared against a programmable compare value. When the two are equal on a tick, the counter wraps to zero and a timer interrupt request is raised. Software can also zero the counter through a self-clearing bit in the control register.

In capture mode, the counter keeps running and keeps wrapping on compare match. In addition, a qualified edge on the capture pin copies the live count into a capture register. A selectable polarity decides which edge qualifies: none, falling, rising or both.

A qualified edge sets the capture interrupt flag in either mode. The capture register is loaded only in capture mode. In capture mode, the compare value and the captured value share one bus address: a read returns the captured count and a write changes the compare value. Each interrupt flag is cleared by its own acknowledge input.

Top module: `cap_timer8`

## Requirements
- R1: The control register is at address 0 and resets to 0x00. It holds enable in bit 7, capture mode in bit 5 and clock select in bits 3:1. Bits 6, 4 and 0 read back as 0.
- R2: With the internal source, clock select values 0 to 7 give one count every 1, 2, 4, 8, 32, 128, 512 or 2048 clock cycles. The first count lands that many cycles after the enable write takes effect.
- R3: On a tick where the count equals the compare value, the count becomes 0 and the timer interrupt output goes to 1 on the same edge.
- R4: A control write with bit 0 set zeroes the counter on that write's clock edge. This takes priority over counting.
- R5: While enable is 0 the count holds its value and the divider is held at zero. After re-enabling, the first count comes a full divide period later.
- R6: In capture mode, a qualified capture-pin edge loads the current count into the capture register on the third clock edge after the pin changes, and sets the capture interrupt output. In timer mode the flag is still set but the capture register is left unchanged.
- R7: Address 3 bits 1:0 select the capture polarity: 00 none, 01 falling, 10 rising, 11 both. An edge that is not selected sets no flag and loads nothing.
- R8: Address 2 reads the capture register in capture mode and the compare value in timer mode. Writes to address 2 always update the compare value, which resets to 0xFF.
- R9: A one-cycle pulse on the timer or capture acknowledge input clears the matching interrupt output on the next edge.
- R10: With address 3 bit 2 set, the counter advances once per rising edge of the external clock input, after the same two-stage synchronisation, and the internal divider is ignored.
- R11: Address 1 returns the live count and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| ext_clk | input | 1 | Asynchronous external count clock |
| tmr_ack | input | 1 | Clears the timer interrupt flag |
| cap_ack | input | 1 | Clears the capture interrupt flag |
| tmr_irq | output | 1 | Timer (compare match) interrupt request |
| cap_irq | output | 1 | Capture-pin interrupt request |

## Verification
The properties take for granted that the capture pin and the external clock are low while reset is held. They also assume that every level on these pins lasts at least two clock cycles, so that each edge is seen exactly once after the synchroniser. The bench holds both pins low through reset and keeps every pin level for three or more cycles. It pulses the acknowledge inputs only in cycles where no new flag is being set.

// File: rtl/cap_timer8_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the 8-bit capture timer.
// Assumes an 8-bit register bus with a 2-bit address.
package cap_timer8_pkg;
    localparam int CS_W = 3;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_DATA  = 2'd2;
    localparam logic [1:0] A_SRC   = 2'd3;

    localparam int B_EN   = 7;
    localparam int B_MODE = 5;
    localparam int B_CS   = 1;
    localparam int B_CLR  = 0;
    localparam int B_EXT  = 2;

    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_FALL = 2'b01,
        POL_RISE = 2'b10,
        POL_BOTH = 2'b11
    } pol_t;

    // log2 of the divide ratio for each clock-select code
    function automatic int div_shift(input logic [CS_W-1:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 5;
            3'd5:    return 7;
            3'd6:    return 9;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
// Count-tick source: a free-running divider tapped by clock select, or the
// synchronised rising edge of an external clock. The divider is held at zero
// while run is low. Assumes ext_clk levels last at least two clk cycles.
module tmr_tick_gen
    import cap_timer8_pkg::*;
#(
    parameter int PRE_W  = 11,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CS_W-1:0] sel,
    input  logic            use_ext,
    input  logic            ext_clk,
    output logic            tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [SYNC_N:0]  ext_s;
    logic             pre_tick;
    logic             ext_rise;

    // divider: counts while running, parked at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // tap mask: low div_shift(sel) bits set
    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < div_shift(sel));
    end

    // synchroniser plus one history stage for the external clock
    always_ff @(posedge clk) begin
        if (!rst_n) ext_s <= '0;
        else        ext_s <= {ext_s[SYNC_N-1:0], ext_clk};
    end

    // select the tick source
    always_comb begin
        pre_tick = ((pre_q & mask) == mask);
        ext_rise = ext_s[SYNC_N-1] & ~ext_s[SYNC_N];
        tick     = run & (use_ext ? ext_rise : pre_tick);
    end
endmodule

// File: rtl/tmr_edge_qual.sv
`timescale 1ns/1ps
// Synchronises the capture pin and flags edges selected by the polarity code.
// Assumes the pin is low during reset and each level lasts two clk cycles.
module tmr_edge_qual
    import cap_timer8_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  pol_t pol,
    output logic hit
);
    logic [SYNC_N:0] s_q;
    logic            rise;
    logic            fall;

    // synchroniser chain with one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_N-1:0], pin};
    end

    // edge detect and polarity qualification
    always_comb begin
        rise = s_q[SYNC_N-1] & ~s_q[SYNC_N];
        fall = ~s_q[SYNC_N-1] & s_q[SYNC_N];
        hit  = (pol[1] & rise) | (pol[0] & fall);
    end
endmodule

// File: rtl/cap_timer8.sv
`timescale 1ns/1ps
// 8-bit timer with compare-match wrap and edge capture.
// Registers: 0 control, 1 count (read only), 2 compare/capture, 3 source.
// Assumes W >= 8; asynchronous pins are synchronised inside.
module cap_timer8
    import cap_timer8_pkg::*;
#(
    parameter int W      = 8,
    parameter int PRE_W  = 11,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         cap_pin,
    input  logic         ext_clk,
    input  logic         tmr_ack,
    input  logic         cap_ack,
    output logic         tmr_irq,
    output logic         cap_irq
);
    logic            en_q, mode_q, ext_sel_q;
    logic [CS_W-1:0] cs_q;
    pol_t            pol_q;
    logic [W-1:0]    data_q, cnt_q, cap_q;
    logic            tmr_flag_q, cap_flag_q;
    logic            wr_ctrl, wr_data, wr_src, sw_clr;
    logic            tick, qual_hit, match_hit;
    logic            unused_bits;

    assign unused_bits = ^{bus_wdata[6], bus_wdata[4]};

    // write decode; the clear bit acts only as a pulse
    always_comb begin
        wr_ctrl   = bus_we && (bus_addr == A_CTRL);
        wr_data   = bus_we && (bus_addr == A_DATA);
        wr_src    = bus_we && (bus_addr == A_SRC);
        sw_clr    = wr_ctrl && bus_wdata[B_CLR];
        match_hit = tick && !sw_clr && (cnt_q == data_q);
    end

    tmr_tick_gen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(en_q), .sel(cs_q),
        .use_ext(ext_sel_q), .ext_clk(ext_clk), .tick(tick)
    );

    tmr_edge_qual #(.SYNC_N(SYNC_N)) edge_i (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .pol(pol_q), .hit(qual_hit)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mode_q    <= 1'b0;
            cs_q      <= '0;
            pol_q     <= POL_OFF;
            ext_sel_q <= 1'b0;
            data_q    <= '1;
        end else begin
            if (wr_ctrl) begin
                en_q   <= bus_wdata[B_EN];
                mode_q <= bus_wdata[B_MODE];
                cs_q   <= bus_wdata[B_CS +: CS_W];
            end
            if (wr_src) begin
                pol_q     <= pol_t'(bus_wdata[1:0]);
                ext_sel_q <= bus_wdata[B_EXT];
            end
            if (wr_data) data_q <= bus_wdata;
        end
    end

    // counter: software clear, then wrap on match, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (sw_clr)    cnt_q <= '0;
        else if (match_hit) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    // capture register and both interrupt flags (set beats acknowledge)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= '0;
            tmr_flag_q <= 1'b0;
            cap_flag_q <= 1'b0;
        end else begin
            if (qual_hit && mode_q) cap_q <= cnt_q;
            if (match_hit)          tmr_flag_q <= 1'b1;
            else if (tmr_ack)       tmr_flag_q <= 1'b0;
            if (qual_hit)           cap_flag_q <= 1'b1;
            else if (cap_ack)       cap_flag_q <= 1'b0;
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[7:0] = {en_q, 1'b0, mode_q, 1'b0, cs_q, 1'b0};
            A_COUNT: bus_rdata = cnt_q;
            A_DATA:  bus_rdata = mode_q ? cap_q : data_q;
            default: bus_rdata[2:0] = {ext_sel_q, pol_q};
        endcase
    end

    assign tmr_irq = tmr_flag_q;
    assign cap_irq = cap_flag_q;
endmodule

// File: rtl/cap_timer8_chk.sv
`timescale 1ns/1ps
// Protocol checker for cap_timer8, bound to every instance.
// Assumes the inputs stay within the limits stated in the brief.
module cap_timer8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         sw_clr,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] data,
    input logic [W-1:0] cap,
    input logic         mode,
    input logic         qual_hit,
    input logic         tmr_ack,
    input logic         cap_ack,
    input logic         tmr_irq,
    input logic         cap_irq
);
    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sw_clr && cnt == data) |=> (cnt == '0 && tmr_irq)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sw_clr && cnt != data) |=> (cnt == W'($past(cnt) + 1'b1))); // R2
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (cnt == '0)); // R4
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sw_clr) |=> $stable(cnt)); // R5
    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick); // R5
    AST_CAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode || !qual_hit) |=> $stable(cap)); // R6
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        qual_hit |=> cap_irq); // R6
    AST_TMR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ack && !(tick && !sw_clr && cnt == data)) |=> !tmr_irq); // R9
    AST_CAP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ack && !qual_hit) |=> !cap_irq); // R9
endmodule

bind cap_timer8 cap_timer8_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en_q), .sw_clr(sw_clr), .tick(tick),
    .cnt(cnt_q), .data(data_q), .cap(cap_q), .mode(mode_q),
    .qual_hit(qual_hit), .tmr_ack(tmr_ack), .cap_ack(cap_ack),
    .tmr_irq(tmr_irq), .cap_irq(cap_irq)
);

// File: tb/cap_timer8_tb_top.sv
`timescale 1ns/1ps
// Directed bench for cap_timer8: one task per scenario.
module cap_timer8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       ext_clk = 1'b0;
    logic       tmr_ack = 1'b0;
    logic       cap_ack = 1'b0;
    logic       tmr_irq, cap_irq;
    int         total = 0;
    int         bad = 0;
    logic [7:0] held;

    always #2 clk = ~clk;

    cap_timer8 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
        .ext_clk(ext_clk), .tmr_ack(tmr_ack), .cap_ack(cap_ack),
        .tmr_irq(tmr_irq), .cap_irq(cap_irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl reset", 2'd0, 8'h00);
        expect_reg("R11 count reset", 2'd1, 8'h00);
        expect_reg("R8 compare reset", 2'd2, 8'hFF);
        expect_reg("R7 source reset", 2'd3, 8'h00);
        check("R3 tmr_irq reset", {7'd0, tmr_irq}, 8'd0);
        check("R6 cap_irq reset", {7'd0, cap_irq}, 8'd0);
    endtask

    task automatic t_ctrl();
        wr(2'd0, 8'hFF);
        expect_reg("R1 ctrl layout", 2'd0, 8'hAE);
        wr(2'd0, 8'h01);
        expect_reg("R4 clear bit reads 0", 2'd0, 8'h00);
        expect_reg("R4 count cleared", 2'd1, 8'h00);
    endtask

    task automatic t_match();
        wr(2'd2, 8'd5);
        wr(2'd0, 8'h80);
        cycles(3);
        expect_reg("R2 div1 count", 2'd1, 8'd3);
        cycles(2);
        expect_reg("R3 count at compare", 2'd1, 8'd5);
        check("R3 no irq before match", {7'd0, tmr_irq}, 8'd0);
        cycles(1);
        expect_reg("R3 wrap to zero", 2'd1, 8'd0);
        check("R3 irq on match", {7'd0, tmr_irq}, 8'd1);
        tmr_ack = 1'b1; cycles(1); tmr_ack = 1'b0;
        check("R9 timer ack", {7'd0, tmr_irq}, 8'd0);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_prescale();
        wr(2'd0, 8'h84);
        cycles(8);
        expect_reg("R2 div4 after 8", 2'd1, 8'd2);
        cycles(4);
        expect_reg("R2 div4 after 12", 2'd1, 8'd3);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h88);
        cycles(64);
        expect_reg("R2 div32 after 64", 2'd1, 8'd2);
        wr(2'd0, 8'h08);
        cycles(40);
        expect_reg("R5 hold while disabled", 2'd1, 8'd2);
        wr(2'd0, 8'h88);
        cycles(31);
        expect_reg("R5 divider restarted", 2'd1, 8'd2);
        cycles(1);
        expect_reg("R5 first count after restart", 2'd1, 8'd3);
        wr(2'd0, 8'h01);
    endtask

    task automatic t_swclr();
        wr(2'd0, 8'h80);
        cycles(10);
        expect_reg("R2 run to 10", 2'd1, 8'd10);
        wr(2'd0, 8'h81);
        expect_reg("R4 clear while running", 2'd1, 8'd0);
        cycles(2);
        expect_reg("R4 counts on after clear", 2'd1, 8'd2);
        wr(2'd0, 8'h01);
    endtask

    task automatic t_capture();
        wr(2'd0, 8'h80);
        cycles(7);
        wr(2'd0, 8'h20);
        expect_reg("R5 frozen count", 2'd1, 8'd8);
        wr(2'd3, 8'h02);
        cap_pin = 1'b1;
        cycles(2);
        check("R6 capture latency", {7'd0, cap_irq}, 8'd0);
        cycles(1);
        check("R6 capture flag", {7'd0, cap_irq}, 8'd1);
        expect_reg("R8 read returns capture", 2'd2, 8'd8);
        wr(2'd2, 8'h33);
        expect_reg("R8 write leaves capture", 2'd2, 8'd8);
        wr(2'd0, 8'h00);
        expect_reg("R8 write went to compare", 2'd2, 8'h33);
        cap_ack = 1'b1; cycles(1); cap_ack = 1'b0;
        check("R9 capture ack", {7'd0, cap_irq}, 8'd0);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_polarity();
        wr(2'd0, 8'hA0);
        cycles(4);
        wr(2'd0, 8'h20);
        expect_reg("R5 frozen count 2", 2'd1, 8'd13);
        cap_pin = 1'b0; cycles(5);
        check("R7 falling ignored on rise", {7'd0, cap_irq}, 8'd0);
        expect_reg("R7 no capture on rise", 2'd2, 8'd8);
        wr(2'd3, 8'h01);
        cap_pin = 1'b1; cycles(5);
        check("R7 rising ignored on fall", {7'd0, cap_irq}, 8'd0);
        cap_pin = 1'b0; cycles(5);
        check("R7 falling captured", {7'd0, cap_irq}, 8'd1);
        expect_reg("R7 falling value", 2'd2, 8'd13);
        cap_ack = 1'b1; cycles(1); cap_ack = 1'b0;
        wr(2'd3, 8'h00);
        cap_pin = 1'b1; cycles(5);
        cap_pin = 1'b0; cycles(5);
        check("R7 off ignores both", {7'd0, cap_irq}, 8'd0);
        wr(2'd3, 8'h03);
        cap_pin = 1'b1; cycles(5);
        check("R7 both: rise", {7'd0, cap_irq}, 8'd1);
        cap_ack = 1'b1; cycles(1); cap_ack = 1'b0;
        cap_pin = 1'b0; cycles(5);
        check("R7 both: fall", {7'd0, cap_irq}, 8'd1);
        cap_ack = 1'b1; cycles(1); cap_ack = 1'b0;
    endtask

    task automatic t_timer_mode_edge();
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h02);
        cap_pin = 1'b1; cycles(5);
        check("R6 flag in timer mode", {7'd0, cap_irq}, 8'd1);
        wr(2'd0, 8'h20);
        expect_reg("R6 no load in timer mode", 2'd2, 8'd13);
        cap_pin = 1'b0; cycles(5);
        cap_ack = 1'b1; cycles(1); cap_ack = 1'b0;
        wr(2'd0, 8'h00);
    endtask

    task automatic t_extclk();
        wr(2'd0, 8'h01);
        wr(2'd3, 8'h04);
        wr(2'd0, 8'h80);
        for (int i = 0; i < 5; i++) begin
            ext_clk = 1'b1; cycles(3);
            ext_clk = 1'b0; cycles(3);
        end
        cycles(4);
        expect_reg("R10 external edges counted", 2'd1, 8'd5);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h55);
        expect_reg("R11 count ignores writes", 2'd1, 8'd5);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired got=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_ctrl();
        t_match();
        t_prescale();
        t_swclr();
        t_capture();
        t_polarity();
        t_timer_mode_edge();
        t_extclk();
        rd(2'd0, held);
        check("R1 final ctrl", held, 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule